// File: doc/BRIEF.md
# Two-Processor Prioritized Interrupt Distributor

This block gathers interrupt requests for a pair of processors and decides, for each processor, which request it should take next. Requests come from three groups. Software requests are raised through the configuration port and are aimed at the writing processor, at the other processor, or at both. Private peripheral lines are banked, so each processor has its own copy. Shared peripheral lines are common to both processors and each one is routed through a two-bit target field.

Every source stores a pending bit, an active bit, an enable bit and a 4-bit priority. For each processor the block shows the ID of the most urgent request it may take, and raises a request line when one exists. A processor takes that request with an acknowledge pulse. The ID it took appears on its acknowledge-ID output on the next cycle. Later the processor returns the same ID with an end-of-interrupt pulse.

All configuration goes through one write port. The port carries an operation code, a requesting/bank CPU select, an interrupt ID and a small data field.

Top module: `irq_dist`

## Requirements
- R1: After reset both request lines are low, and both pending-ID and acknowledge-ID outputs read 1023.
- R2: A configuration write with operation 3 raises software interrupt ID `cfg_id_i[3:0]`. The target comes from `cfg_data_i[1:0]`: 0 means the writing CPU (`cfg_cpu_i`), 1 the other CPU, 2 both, and 3 none. The interrupt shows as pending one clock edge after the write.
- R3: Private input k of CPU c is interrupt ID 16+k and is seen only by CPU c. The input passes through two synchronizer flops, so it becomes pending on the third rising edge after it goes high.
- R4: Shared input i is interrupt ID 32+i. Operation 2 writes its target field from `cfg_data_i[1:0]`: bit 0 routes it to CPU0 and bit 1 to CPU1. A CPU whose bit is clear never sees it.
- R5: Among the signalled candidates, the lowest priority value wins. Operation 1 writes `cfg_data_i`. Equal priorities go to the lowest ID.
- R6: A disabled source still latches pending but is never signalled. Operation 0 writes `cfg_data_i[0]` as the enable, and enabling a source that is already pending signals it.
- R7: An acknowledge pulse moves the offered interrupt from pending to active, and its ID appears on `ack_id_o` one cycle later. An acknowledge with nothing offered returns 1023 and changes no state.
- R8: While a CPU has active interrupts, it is only offered pending interrupts whose priority value is strictly lower than the lowest value among its active ones.
- R9: End-of-interrupt clears the active bit of the returned ID. For a shared ID, this happens only when the CPU that claimed it sends the end-of-interrupt; from the other CPU it is ignored.
- R10: A shared interrupt routed to both CPUs belongs to the first CPU that acknowledges it, and the other CPU no longer sees it. If both acknowledge in the same cycle, CPU0 gets it and CPU1 receives 1023.
- R11: A peripheral line that is held high does not pend again while its interrupt is active. It pends again one edge after the end-of-interrupt clears the active bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ppi_i | input | 2x5 | Private peripheral levels, one group per CPU |
| spi_i | input | 60 | Shared peripheral levels |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_cpu_i | input | 1 | Writing CPU, which also selects the bank for IDs 0..31 |
| cfg_op_i | input | 2 | 0 enable, 1 priority, 2 route, 3 software raise |
| cfg_id_i | input | 10 | Interrupt ID addressed |
| cfg_data_i | input | 4 | Write data |
| ack_i | input | 2 | Acknowledge pulse per CPU |
| eoi_i | input | 2 | End-of-interrupt pulse per CPU |
| eoi_id_i | input | 2x10 | ID returned with end-of-interrupt |
| irq_o | output | 2 | Request line per CPU |
| hpp_id_o | output | 2x10 | ID currently offered per CPU, 1023 when none |
| ack_id_o | output | 2x10 | ID taken by the last acknowledge |

## Verification
A table of shared-line pairs varies the priorities and the target fields. It separates priority order from ID order, single routing from dual routing, and the unrouted case. Software raises in each target mode show whether a write reaches the wrong bank. The private line is sampled before and after the synchronizer delay, which confirms both the latency and the per-CPU banking. Nested acknowledges of equal and more urgent priorities exercise the preemption threshold. End-of-interrupt from the wrong CPU, together with simultaneous acknowledges of a dually routed line, exercises the ownership rules.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int NCPU        = 2;
  localparam int ID_W        = 10;
  localparam int LOCAL_SLOTS = 32;
  localparam int SGI_N       = 16;
  localparam int PPI_BASE    = 16;
  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

  typedef enum logic [1:0] {
    OP_ENABLE = 2'd0,
    OP_PRIO   = 2'd1,
    OP_ROUTE  = 2'd2,
    OP_SOFT   = 2'd3
  } cfg_op_e;

  typedef enum logic [1:0] {
    SOFT_SELF  = 2'd0,
    SOFT_OTHER = 2'd1,
    SOFT_BOTH  = 2'd2,
    SOFT_NONE  = 2'd3
  } soft_tgt_e;
endpackage

// File: rtl/irq_dist_sync.sv
module irq_dist_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_dist_arb.sv
module irq_dist_arb
  import irq_dist_pkg::*;
#(
  parameter int N      = 92,
  parameter int PRIO_W = 4
) (
  input  logic [N-1:0]             cand_i,
  input  logic [N-1:0]             act_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  output logic                     valid_o,
  output logic [ID_W-1:0]          id_o
);
  localparam int PX = PRIO_W + 1;
  localparam logic [PX-1:0] IDLE_P = {1'b1, {PRIO_W{1'b0}}};

  logic [PX-1:0]   best_p;
  logic [PX-1:0]   run_p;
  logic [ID_W-1:0] best_id;

  // Ascending scan with strict compare keeps the lowest ID on ties.
  always_comb begin
    best_p  = IDLE_P;
    run_p   = IDLE_P;
    best_id = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && ({1'b0, prio_i[i]} < best_p)) begin
        best_p  = {1'b0, prio_i[i]};
        best_id = ID_W'(i);
      end
      if (act_i[i] && ({1'b0, prio_i[i]} < run_p)) begin
        run_p = {1'b0, prio_i[i]};
      end
    end
  end

  assign valid_o = (best_p < run_p);
  assign id_o    = best_id;
endmodule

// File: rtl/irq_dist_bank.sv
module irq_dist_bank
  import irq_dist_pkg::*;
#(
  parameter int NUM_PPI = 5,
  parameter int PRIO_W  = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_en_we_i,
  input  logic                                 cfg_prio_we_i,
  input  logic [$clog2(LOCAL_SLOTS)-1:0]       cfg_idx_i,
  input  logic [PRIO_W-1:0]                    cfg_data_i,
  input  logic [SGI_N-1:0]                     soft_set_i,
  input  logic [NUM_PPI-1:0]                   ppi_lvl_i,
  input  logic                                 take_i,
  input  logic [$clog2(LOCAL_SLOTS)-1:0]       take_idx_i,
  input  logic                                 eoi_i,
  input  logic [$clog2(LOCAL_SLOTS)-1:0]       eoi_idx_i,
  output logic [LOCAL_SLOTS-1:0]               pend_o,
  output logic [LOCAL_SLOTS-1:0]               act_o,
  output logic [LOCAL_SLOTS-1:0]               en_o,
  output logic [LOCAL_SLOTS-1:0][PRIO_W-1:0]   prio_o
);
  localparam int IDX_W = $clog2(LOCAL_SLOTS);

  for (genvar i = 0; i < LOCAL_SLOTS; i++) begin : g_slot
    if (i < SGI_N || (i >= PPI_BASE && i < PPI_BASE + NUM_PPI)) begin : g_live
      logic              take_hit, eoi_hit, cfg_hit, set_hit;
      logic              pend_q, pend_d, act_q, act_d, en_q, en_d;
      logic [PRIO_W-1:0] prio_q, prio_d;

      assign take_hit = take_i && (take_idx_i == IDX_W'(i));
      assign eoi_hit  = eoi_i  && (eoi_idx_i  == IDX_W'(i));
      assign cfg_hit  = (cfg_idx_i == IDX_W'(i));

      if (i < SGI_N) begin : g_soft
        assign set_hit = soft_set_i[i];
      end else begin : g_lvl
        assign set_hit = ppi_lvl_i[i-PPI_BASE] && !act_q && !take_hit;
      end

      always_comb begin
        pend_d = (pend_q && !take_hit) || set_hit;
        act_d  = (act_q && !eoi_hit) || take_hit;
        en_d   = en_q;
        prio_d = prio_q;
        if (cfg_en_we_i && cfg_hit)   en_d   = cfg_data_i[0];
        if (cfg_prio_we_i && cfg_hit) prio_d = cfg_data_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
          act_q  <= 1'b0;
          en_q   <= 1'b0;
          prio_q <= '0;
        end else begin
          pend_q <= pend_d;
          act_q  <= act_d;
          if (cfg_en_we_i)   en_q   <= en_d;
          if (cfg_prio_we_i) prio_q <= prio_d;
        end
      end

      assign pend_o[i] = pend_q;
      assign act_o[i]  = act_q;
      assign en_o[i]   = en_q;
      assign prio_o[i] = prio_q;
    end else begin : g_hole
      assign pend_o[i] = 1'b0;
      assign act_o[i]  = 1'b0;
      assign en_o[i]   = 1'b0;
      assign prio_o[i] = '0;
    end
  end

  AST_TAKE_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> pend_o[take_idx_i]); // R7
  AST_TAKE_MAKES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> act_o[$past(take_idx_i)]); // R7
endmodule

// File: rtl/irq_dist_shared.sv
module irq_dist_shared
  import irq_dist_pkg::*;
#(
  parameter int NUM_SPI = 60,
  parameter int PRIO_W  = 4
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       cfg_en_we_i,
  input  logic                                       cfg_prio_we_i,
  input  logic                                       cfg_route_we_i,
  input  logic [$clog2(NUM_SPI)-1:0]                 cfg_idx_i,
  input  logic [PRIO_W-1:0]                          cfg_data_i,
  input  logic [NUM_SPI-1:0]                         lvl_i,
  input  logic [NCPU-1:0]                            take_i,
  input  logic [NCPU-1:0][$clog2(NUM_SPI)-1:0]       take_idx_i,
  input  logic [NCPU-1:0]                            eoi_i,
  input  logic [NCPU-1:0][$clog2(NUM_SPI)-1:0]       eoi_idx_i,
  output logic [NUM_SPI-1:0]                         pend_o,
  output logic [NUM_SPI-1:0]                         act_o,
  output logic [NUM_SPI-1:0]                         en_o,
  output logic [NUM_SPI-1:0]                         owner_o,
  output logic [NUM_SPI-1:0][NCPU-1:0]               route_o,
  output logic [NUM_SPI-1:0][PRIO_W-1:0]             prio_o
);
  localparam int SIDX_W = $clog2(NUM_SPI);

  for (genvar i = 0; i < NUM_SPI; i++) begin : g_src
    logic [NCPU-1:0]   take_hit;
    logic              any_take, eoi_hit, cfg_hit;
    logic              pend_q, pend_d, act_q, act_d, en_q, en_d, own_q, own_d;
    logic [NCPU-1:0]   route_q, route_d;
    logic [PRIO_W-1:0] prio_q, prio_d;

    assign cfg_hit = (cfg_idx_i == SIDX_W'(i));

    always_comb begin
      eoi_hit = 1'b0;
      for (int c = 0; c < NCPU; c++) begin
        take_hit[c] = take_i[c] && (take_idx_i[c] == SIDX_W'(i));
        if (eoi_i[c] && (eoi_idx_i[c] == SIDX_W'(i)) && (own_q == 1'(c))) eoi_hit = 1'b1;
      end
      any_take = |take_hit;
      own_d    = take_hit[1] ? 1'b1 : (take_hit[0] ? 1'b0 : own_q);
      pend_d   = (pend_q || (lvl_i[i] && !act_q)) && !any_take;
      act_d    = (act_q && !eoi_hit) || any_take;
      en_d     = (cfg_en_we_i && cfg_hit) ? cfg_data_i[0] : en_q;
      prio_d   = (cfg_prio_we_i && cfg_hit) ? cfg_data_i : prio_q;
      route_d  = (cfg_route_we_i && cfg_hit) ? cfg_data_i[NCPU-1:0] : route_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q  <= 1'b0;
        act_q   <= 1'b0;
        own_q   <= 1'b0;
        en_q    <= 1'b0;
        prio_q  <= '0;
        route_q <= '0;
      end else begin
        pend_q <= pend_d;
        act_q  <= act_d;
        if (any_take)       own_q   <= own_d;
        if (cfg_en_we_i)    en_q    <= en_d;
        if (cfg_prio_we_i)  prio_q  <= prio_d;
        if (cfg_route_we_i) route_q <= route_d;
      end
    end

    assign pend_o[i]  = pend_q;
    assign act_o[i]   = act_q;
    assign en_o[i]    = en_q;
    assign owner_o[i] = own_q;
    assign route_o[i] = route_q;
    assign prio_o[i]  = prio_q;
  end

  AST_SINGLE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_i[0] && take_i[1] && (take_idx_i[0] == take_idx_i[1]))); // R10
  AST_CLAIM0_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take_i[0] |-> pend_o[take_idx_i[0]]); // R10
  AST_CLAIM1_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take_i[1] |-> pend_o[take_idx_i[1]]); // R10
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int NUM_PPI = 5,
  parameter int NUM_SPI = 60,
  parameter int PRIO_W  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NCPU-1:0][NUM_PPI-1:0]      ppi_i,
  input  logic [NUM_SPI-1:0]                spi_i,
  input  logic                              cfg_we_i,
  input  logic                              cfg_cpu_i,
  input  logic [1:0]                        cfg_op_i,
  input  logic [ID_W-1:0]                   cfg_id_i,
  input  logic [PRIO_W-1:0]                 cfg_data_i,
  input  logic [NCPU-1:0]                   ack_i,
  input  logic [NCPU-1:0]                   eoi_i,
  input  logic [NCPU-1:0][ID_W-1:0]         eoi_id_i,
  output logic [NCPU-1:0]                   irq_o,
  output logic [NCPU-1:0][ID_W-1:0]         hpp_id_o,
  output logic [NCPU-1:0][ID_W-1:0]         ack_id_o
);
  localparam int ID_SPACE = LOCAL_SLOTS + NUM_SPI;
  localparam int LIDX_W   = $clog2(LOCAL_SLOTS);
  localparam int SIDX_W   = $clog2(NUM_SPI);
  localparam logic [ID_W-1:0] SPI_BASE = ID_W'(LOCAL_SLOTS);
  localparam logic [ID_W-1:0] SPI_END  = ID_W'(ID_SPACE);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // peripheral synchronizers
  logic [NCPU-1:0][NUM_PPI-1:0] ppi_sync;
  logic [NUM_SPI-1:0]           spi_sync;

  irq_dist_sync #(.W(NCPU*NUM_PPI)) u_ppi_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(ppi_i), .q_o(ppi_sync));
  irq_dist_sync #(.W(NUM_SPI)) u_spi_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(spi_i), .q_o(spi_sync));

  // configuration decode
  logic cfg_local, cfg_shared;
  logic [SIDX_W-1:0] cfg_sidx;
  assign cfg_local  = (cfg_id_i < SPI_BASE);
  assign cfg_shared = (cfg_id_i >= SPI_BASE) && (cfg_id_i < SPI_END);
  assign cfg_sidx   = SIDX_W'(cfg_id_i - SPI_BASE);

  // arbitration results and claims
  logic [NCPU-1:0]                  sel_valid;
  logic [NCPU-1:0][ID_W-1:0]        sel_id;
  logic [NCPU-1:0]                  take_ok;
  logic [NCPU-1:0]                  sp_take;
  logic [NCPU-1:0][SIDX_W-1:0]      sp_take_idx;
  logic [NCPU-1:0]                  sp_eoi;
  logic [NCPU-1:0][SIDX_W-1:0]      sp_eoi_idx;
  logic [NCPU-1:0][ID_W-1:0]        ack_id_d, ack_id_q;

  always_comb begin
    take_ok[0] = ack_i[0] && sel_valid[0];
    take_ok[1] = ack_i[1] && sel_valid[1] &&
                 !(take_ok[0] && (sel_id[0] == sel_id[1]) && (sel_id[1] >= SPI_BASE));
  end

  // banked local state
  logic [NCPU-1:0][LOCAL_SLOTS-1:0]             loc_pend, loc_act, loc_en;
  logic [NCPU-1:0][LOCAL_SLOTS-1:0][PRIO_W-1:0] loc_prio;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic             bank_sel, soft_hit;
    logic [SGI_N-1:0] soft_set;

    assign bank_sel = cfg_we_i && cfg_local && (cfg_cpu_i == 1'(c));
    assign soft_hit = cfg_we_i && (cfg_op_i == OP_SOFT) &&
                      (((cfg_data_i[1:0] == SOFT_SELF)  && (cfg_cpu_i == 1'(c))) ||
                       ((cfg_data_i[1:0] == SOFT_OTHER) && (cfg_cpu_i != 1'(c))) ||
                        (cfg_data_i[1:0] == SOFT_BOTH));
    assign soft_set = soft_hit ? (SGI_N'(1) << cfg_id_i[3:0]) : '0;

    irq_dist_bank #(.NUM_PPI(NUM_PPI), .PRIO_W(PRIO_W)) u_bank (
      .clk           (clk),
      .rst_n         (rst_sync_n),
      .cfg_en_we_i   (bank_sel && (cfg_op_i == OP_ENABLE)),
      .cfg_prio_we_i (bank_sel && (cfg_op_i == OP_PRIO)),
      .cfg_idx_i     (cfg_id_i[LIDX_W-1:0]),
      .cfg_data_i    (cfg_data_i),
      .soft_set_i    (soft_set),
      .ppi_lvl_i     (ppi_sync[c]),
      .take_i        (take_ok[c] && (sel_id[c] < SPI_BASE)),
      .take_idx_i    (sel_id[c][LIDX_W-1:0]),
      .eoi_i         (eoi_i[c] && (eoi_id_i[c] < SPI_BASE)),
      .eoi_idx_i     (eoi_id_i[c][LIDX_W-1:0]),
      .pend_o        (loc_pend[c]),
      .act_o         (loc_act[c]),
      .en_o          (loc_en[c]),
      .prio_o        (loc_prio[c])
    );

    assign sp_take[c]     = take_ok[c] && (sel_id[c] >= SPI_BASE);
    assign sp_take_idx[c] = SIDX_W'(sel_id[c] - SPI_BASE);
    assign sp_eoi[c]      = eoi_i[c] && (eoi_id_i[c] >= SPI_BASE) && (eoi_id_i[c] < SPI_END);
    assign sp_eoi_idx[c]  = SIDX_W'(eoi_id_i[c] - SPI_BASE);
  end

  // shared state
  logic [NUM_SPI-1:0]             spi_pend, spi_act, spi_en, spi_owner;
  logic [NUM_SPI-1:0][NCPU-1:0]   spi_route;
  logic [NUM_SPI-1:0][PRIO_W-1:0] spi_prio;

  irq_dist_shared #(.NUM_SPI(NUM_SPI), .PRIO_W(PRIO_W)) u_shared (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .cfg_en_we_i    (cfg_we_i && cfg_shared && (cfg_op_i == OP_ENABLE)),
    .cfg_prio_we_i  (cfg_we_i && cfg_shared && (cfg_op_i == OP_PRIO)),
    .cfg_route_we_i (cfg_we_i && cfg_shared && (cfg_op_i == OP_ROUTE)),
    .cfg_idx_i      (cfg_sidx),
    .cfg_data_i     (cfg_data_i),
    .lvl_i          (spi_sync),
    .take_i         (sp_take),
    .take_idx_i     (sp_take_idx),
    .eoi_i          (sp_eoi),
    .eoi_idx_i      (sp_eoi_idx),
    .pend_o         (spi_pend),
    .act_o          (spi_act),
    .en_o           (spi_en),
    .owner_o        (spi_owner),
    .route_o        (spi_route),
    .prio_o         (spi_prio)
  );

  // per-CPU candidate view over the whole ID space
  logic [NCPU-1:0][ID_SPACE-1:0]             cand, actv;
  logic [NCPU-1:0][ID_SPACE-1:0][PRIO_W-1:0] prio_all;

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      for (int i = 0; i < LOCAL_SLOTS; i++) begin
        cand[c][i]     = loc_pend[c][i] && loc_en[c][i];
        actv[c][i]     = loc_act[c][i];
        prio_all[c][i] = loc_prio[c][i];
      end
      for (int s = 0; s < NUM_SPI; s++) begin
        cand[c][LOCAL_SLOTS+s]     = spi_pend[s] && spi_en[s] && spi_route[s][c];
        actv[c][LOCAL_SLOTS+s]     = spi_act[s] && (spi_owner[s] == 1'(c));
        prio_all[c][LOCAL_SLOTS+s] = spi_prio[s];
      end
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_arb
    irq_dist_arb #(.N(ID_SPACE), .PRIO_W(PRIO_W)) u_arb (
      .cand_i  (cand[c]),
      .act_i   (actv[c]),
      .prio_i  (prio_all[c]),
      .valid_o (sel_valid[c]),
      .id_o    (sel_id[c])
    );

    assign ack_id_d[c] = take_ok[c] ? sel_id[c] : ID_NONE;

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        ack_id_q[c] <= ID_NONE;
      end else if (ack_i[c]) begin
        ack_id_q[c] <= ack_id_d[c];
      end
    end

    assign irq_o[c]    = sel_valid[c];
    assign hpp_id_o[c] = sel_valid[c] ? sel_id[c] : ID_NONE;
    assign ack_id_o[c] = ack_id_q[c];

    AST_IDLE_ACK_NONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ack_i[c] && !irq_o[c]) |=> (ack_id_o[c] == ID_NONE)); // R7
  end

  AST_ACK0_GETS_OFFER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_i[0] && irq_o[0]) |=> (ack_id_o[0] == $past(hpp_id_o[0]))); // R7
  AST_TIE_CPU1_LOSES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_i[0] && ack_i[1] && irq_o[0] && irq_o[1] && (hpp_id_o[0] == hpp_id_o[1]) &&
     (hpp_id_o[0] >= SPI_BASE)) |=> (ack_id_o[1] == ID_NONE)); // R10
endmodule

// File: tb/irq_dist_bench.sv
module irq_dist_bench;
  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0][4:0]  ppi_i;
  logic [59:0]      spi_i;
  logic             cfg_we_i, cfg_cpu_i;
  logic [1:0]       cfg_op_i;
  logic [9:0]       cfg_id_i;
  logic [3:0]       cfg_data_i;
  logic [1:0]       ack_i, eoi_i;
  logic [1:0][9:0]  eoi_id_i;
  logic [1:0]       irq_o;
  logic [1:0][9:0]  hpp_id_o, ack_id_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_dist u_irq_dist (
    .clk(clk), .rst_n(rst_n), .ppi_i(ppi_i), .spi_i(spi_i),
    .cfg_we_i(cfg_we_i), .cfg_cpu_i(cfg_cpu_i), .cfg_op_i(cfg_op_i),
    .cfg_id_i(cfg_id_i), .cfg_data_i(cfg_data_i), .ack_i(ack_i),
    .eoi_i(eoi_i), .eoi_id_i(eoi_id_i), .irq_o(irq_o),
    .hpp_id_o(hpp_id_o), .ack_id_o(ack_id_o));

  localparam int NONE = 1023;

  typedef struct packed {
    logic [5:0] a;
    logic [3:0] pa;
    logic [5:0] b;
    logic [3:0] pb;
    logic [1:0] tgt;
    logic [9:0] e0;
    logic [9:0] e1;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{6'd0,  4'd5,  6'd1,  4'd3,  2'b01, 10'd33,   10'd1023},
    '{6'd10, 4'd7,  6'd4,  4'd7,  2'b10, 10'd1023, 10'd36},
    '{6'd59, 4'd0,  6'd20, 4'd9,  2'b11, 10'd91,   10'd91},
    '{6'd2,  4'd15, 6'd3,  4'd15, 2'b00, 10'd1023, 10'd1023},
    '{6'd44, 4'd2,  6'd43, 4'd1,  2'b01, 10'd75,   10'd1023},
    '{6'd7,  4'd4,  6'd8,  4'd4,  2'b11, 10'd39,   10'd39}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(int cpu, int op, int id, int data);
    cfg_we_i   = 1'b1;
    cfg_cpu_i  = 1'(cpu);
    cfg_op_i   = 2'(op);
    cfg_id_i   = 10'(id);
    cfg_data_i = 4'(data);
    @(negedge clk);
    cfg_we_i   = 1'b0;
  endtask

  task automatic do_ack(int c);
    ack_i[c] = 1'b1;
    @(negedge clk);
    ack_i[c] = 1'b0;
  endtask

  task automatic do_eoi(int c, int id);
    eoi_i[c]    = 1'b1;
    eoi_id_i[c] = 10'(id);
    @(negedge clk);
    eoi_i[c]    = 1'b0;
  endtask

  task automatic drain(int c);
    for (int k = 0; k < 8; k++) begin
      if (irq_o[c]) begin
        int id;
        id = int'(hpp_id_o[c]);
        do_ack(c);
        do_eoi(c, id);
      end
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ppi_i = '0; spi_i = '0; cfg_we_i = 1'b0; cfg_cpu_i = 1'b0;
    cfg_op_i = '0; cfg_id_i = '0; cfg_data_i = '0; ack_i = '0; eoi_i = '0; eoi_id_i = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);

    // R1 reset state
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 hpp0", int'(hpp_id_o[0]), NONE);
    chk("R1 hpp1", int'(hpp_id_o[1]), NONE);
    chk("R1 ack0", int'(ack_id_o[0]), NONE);
    chk("R1 ack1", int'(ack_id_o[1]), NONE);

    // R4 R5 table of shared-line pairs
    foreach (VEC[v]) begin
      cfg(0, 0, 32 + int'(VEC[v].a), 1);
      cfg(0, 0, 32 + int'(VEC[v].b), 1);
      cfg(0, 1, 32 + int'(VEC[v].a), int'(VEC[v].pa));
      cfg(0, 1, 32 + int'(VEC[v].b), int'(VEC[v].pb));
      cfg(0, 2, 32 + int'(VEC[v].a), int'(VEC[v].tgt));
      cfg(0, 2, 32 + int'(VEC[v].b), int'(VEC[v].tgt));
      spi_i[VEC[v].a] = 1'b1;
      spi_i[VEC[v].b] = 1'b1;
      wait_n(3);
      chk("R4/R5 cpu0", int'(hpp_id_o[0]), int'(VEC[v].e0));
      chk("R4/R5 cpu1", int'(hpp_id_o[1]), int'(VEC[v].e1));
      spi_i = '0;
      cfg(0, 2, 32 + int'(VEC[v].a), 3);
      cfg(0, 2, 32 + int'(VEC[v].b), 3);
      drain(0);
      drain(1);
      cfg(0, 2, 32 + int'(VEC[v].a), 0);
      cfg(0, 2, 32 + int'(VEC[v].b), 0);
      cfg(0, 0, 32 + int'(VEC[v].a), 0);
      cfg(0, 0, 32 + int'(VEC[v].b), 0);
    end

    // R2 software raise target modes
    cfg(0, 0, 5, 1);
    cfg(1, 0, 5, 1);
    cfg(0, 3, 5, 0);
    chk("R2 self cpu0", int'(hpp_id_o[0]), 5);
    chk("R2 self cpu1", int'(hpp_id_o[1]), NONE);
    drain(0);
    cfg(0, 3, 5, 1);
    chk("R2 other cpu0", int'(hpp_id_o[0]), NONE);
    chk("R2 other cpu1", int'(hpp_id_o[1]), 5);
    drain(1);
    cfg(1, 3, 5, 2);
    chk("R2 both cpu0", int'(hpp_id_o[0]), 5);
    chk("R2 both cpu1", int'(hpp_id_o[1]), 5);
    drain(0);
    drain(1);
    cfg(0, 3, 5, 3);
    chk("R2 none", int'(irq_o), 0);

    // R6 disabled source latches pending
    cfg(0, 3, 7, 0);
    chk("R6 disabled hidden", int'(hpp_id_o[0]), NONE);
    cfg(0, 0, 7, 1);
    chk("R6 enable reveals", int'(hpp_id_o[0]), 7);
    drain(0);

    // R3 private line latency and banking, R11 level re-pend
    cfg(0, 0, 18, 1);
    cfg(1, 0, 18, 1);
    cfg(1, 1, 18, 2);
    ppi_i[1][2] = 1'b1;
    wait_n(2);
    chk("R3 not before sync", int'(hpp_id_o[1]), NONE);
    wait_n(1);
    chk("R3 after sync", int'(hpp_id_o[1]), 18);
    chk("R3 banked", int'(hpp_id_o[0]), NONE);
    do_ack(1);
    chk("R7 ack id", int'(ack_id_o[1]), 18);
    chk("R11 no re-pend active", int'(hpp_id_o[1]), NONE);
    wait_n(2);
    chk("R11 still quiet", int'(hpp_id_o[1]), NONE);
    do_eoi(1, 18);
    wait_n(1);
    chk("R11 re-pend after eoi", int'(hpp_id_o[1]), 18);
    ppi_i = '0;
    wait_n(3);
    drain(1);

    // R7 acknowledge with nothing offered
    do_ack(0);
    chk("R7 idle ack", int'(ack_id_o[0]), NONE);
    chk("R7 idle no change", int'(hpp_id_o[0]), NONE);

    // R8 preemption threshold
    cfg(0, 0, 37, 1);
    cfg(0, 1, 37, 6);
    cfg(0, 2, 37, 1);
    spi_i[5] = 1'b1;
    wait_n(3);
    do_ack(0);
    chk("R7 shared ack", int'(ack_id_o[0]), 37);
    spi_i[5] = 1'b0;
    wait_n(3);
    cfg(0, 0, 3, 1);
    cfg(0, 1, 3, 6);
    cfg(0, 3, 3, 0);
    chk("R8 equal blocked", int'(hpp_id_o[0]), NONE);
    cfg(0, 0, 2, 1);
    cfg(0, 1, 2, 5);
    cfg(0, 3, 2, 0);
    chk("R8 higher preempts", int'(hpp_id_o[0]), 2);
    do_ack(0);
    chk("R8 nested ack", int'(ack_id_o[0]), 2);
    do_eoi(0, 2);
    chk("R8 outer still runs", int'(hpp_id_o[0]), NONE);
    do_eoi(0, 37);
    chk("R9 eoi releases", int'(hpp_id_o[0]), 3);
    drain(0);

    // R9 R10 ownership of a dual-routed line
    cfg(0, 0, 38, 1);
    cfg(0, 1, 38, 3);
    cfg(0, 2, 38, 3);
    spi_i[6] = 1'b1;
    wait_n(3);
    chk("R10 seen cpu0", int'(hpp_id_o[0]), 38);
    chk("R10 seen cpu1", int'(hpp_id_o[1]), 38);
    do_ack(1);
    chk("R10 claim cpu1", int'(ack_id_o[1]), 38);
    chk("R10 gone from cpu0", int'(hpp_id_o[0]), NONE);
    spi_i[6] = 1'b0;
    wait_n(3);
    cfg(1, 0, 9, 1);
    cfg(1, 1, 9, 3);
    cfg(1, 3, 9, 0);
    chk("R8 blocked by owner", int'(hpp_id_o[1]), NONE);
    do_eoi(0, 38);
    chk("R9 wrong owner ignored", int'(hpp_id_o[1]), NONE);
    do_eoi(1, 38);
    chk("R9 owner eoi", int'(hpp_id_o[1]), 9);
    drain(1);

    // R10 simultaneous acknowledge
    cfg(0, 0, 43, 1);
    cfg(0, 1, 43, 1);
    cfg(0, 2, 43, 3);
    spi_i[11] = 1'b1;
    wait_n(3);
    spi_i[11] = 1'b0;
    wait_n(3);
    ack_i = 2'b11;
    @(negedge clk);
    ack_i = 2'b00;
    chk("R10 tie cpu0", int'(ack_id_o[0]), 43);
    chk("R10 tie cpu1", int'(ack_id_o[1]), NONE);
    do_eoi(0, 43);
    chk("R10 all clear", int'(irq_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule